// File: doc/BRIEF.md
# Serial Gain-Control Register Port

This block is the serial control port of a programmable-gain amplifier. A host drives a 4-wire serial link (clock, data in, data out and an active-low select). The block oversamples the serial clock, select and data-in lines in its own system clock domain. It decodes 16-bit frames and holds the small register file that sets the amplifier's power state, its two channel attenuations and its channel control.

Each frame starts with a command byte and ends with a data byte. The command byte carries a read flag, four reserved bits and a register address. A write takes effect only when select is released after exactly sixteen serial clocks. Any frame shorter or longer than that is dropped without a trace. A read returns the addressed register on the data-out line during the data byte. The four writable registers are presented as parallel outputs to the downstream gain logic.

Top module: `gain_spi_regs`

## Requirements
- R1: After reset the parallel outputs hold power 0x00, attenuation A 0x50, attenuation B 0x50 and channel control 0x03.
- R2: A frame is the bits sampled on rising serial-clock edges while select is low, MSB first. Command byte bit 7 is 1 for read and 0 for write, bits 6:3 are reserved, bits 2:0 are the address, and the second byte is data.
- R3: A valid write changes its output only after select rises. While select is still low, every output keeps its old value.
- R4: A frame with fewer than 16 rising serial-clock edges before select rises writes nothing.
- R5: A frame with more than 16 rising serial-clock edges before select rises writes nothing.
- R6: Writable addresses are 2 (power), 3 (attenuation A), 4 (attenuation B) and 5 (channel control). A write to address 0, 1, 6 or 7 changes nothing.
- R7: On a read, the addressed byte leaves MSB first. Each bit is valid after the falling serial-clock edge that follows rising edges 8 through 15. The data byte received on a read changes nothing.
- R8: Address 0 reads 0x01 and address 1 reads 0x21. Addresses 6 and 7 read 0x00.
- R9: The data-out enable is high exactly while select is low. Data-out is 0 while disabled, during the command byte, and throughout a write frame.
- R10: A command with any reserved bit set writes nothing, and its read returns 0x00.
- R11: A value written to a writable address reads back unchanged and appears on that address's parallel output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| spi_clk | input | 1 | Serial clock from the host |
| spi_csn | input | 1 | Active-low frame select |
| spi_sdi | input | 1 | Serial data from the host |
| spi_sdo | output | 1 | Serial data to the host |
| spi_sdo_oe | output | 1 | Output enable for the data-out driver |
| pwr_ctrl | output | 8 | Power control register |
| atten_a | output | 8 | Channel A attenuation register |
| atten_b | output | 8 | Channel B attenuation register |
| chan_ctrl | output | 8 | Channel control register |

## Verification
Each serial line goes through two synchronizer flops and one edge-detect flop. A registered commit strobe follows, so a write reaches the parallel outputs on the fourth system edge after select rises. The bench waits six cycles before comparing and also compares just before releasing select. Read bits appear about three cycles after a falling serial edge. The bench holds each serial half period for six system cycles and samples data-out at the end of the low phase, just before the next rising edge.

// File: rtl/gspi_pkg.sv
package gspi_pkg;

    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 3;
    localparam int NUM_REGS   = 6;
    localparam int RSVD_W     = DATA_W - 1 - ADDR_W;
    localparam int FRAME_BITS = 2 * DATA_W;
    localparam int CNT_MAX    = FRAME_BITS + 1;
    localparam int CNT_W      = $clog2(CNT_MAX + 1);
    localparam int SYNC_STAGES = 2;

    localparam logic [CNT_W-1:0] CNT_BYTE   = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] CNT_FRAME  = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_SAT    = CNT_W'(CNT_MAX);

    // Writable entries and reset values, index = register address
    localparam logic [NUM_REGS-1:0] WR_MASK = 6'b111100;
    localparam logic [NUM_REGS-1:0][DATA_W-1:0] RST_VALS =
        {8'h03, 8'h50, 8'h50, 8'h00, 8'h21, 8'h01};

    typedef enum logic [ADDR_W-1:0] {
        ADR_REV  = 3'd0,
        ADR_PROD = 3'd1,
        ADR_PWR  = 3'd2,
        ADR_ATTA = 3'd3,
        ADR_ATTB = 3'd4,
        ADR_CHAN = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic              rd;
        logic [RSVD_W-1:0] rsvd;
        logic [ADDR_W-1:0] addr;
    } cmd_t;

    typedef struct packed {
        logic              stb;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    function automatic logic cmd_ok(input cmd_t c);
        return (c.rsvd == '0);
    endfunction

endpackage

// File: rtl/gspi_sync.sv
module gspi_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic q
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= {STAGES{RST_VAL}};
        else     pipe <= {pipe[STAGES-2:0], din};
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/gspi_frame.sv
module gspi_frame
    import gspi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              csn_lvl,
    input  logic              csn_rise,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              sdi_lvl,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output wr_req_t           wr_req,
    output logic              sdo_bit
);
    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] out_sh;
    cmd_t              cmd_q;

    // Rising-edge counter, saturating one past a full frame
    always_ff @(posedge clk) begin
        if (rst || csn_lvl)                   bit_cnt <= '0;
        else if (sclk_rise && bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            cmd_q <= '0;
        end else if (!csn_lvl && sclk_rise) begin
            shreg <= {shreg[DATA_W-2:0], sdi_lvl};
            if (bit_cnt == CNT_BYTE - 1'b1)
                cmd_q <= cmd_t'({shreg[DATA_W-2:0], sdi_lvl});
        end
    end

    assign rd_addr = cmd_q.addr;

    // Commit only at deselect after exactly one full frame
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_req <= '0;
        end else begin
            wr_req.stb  <= csn_rise && (bit_cnt == CNT_FRAME) && !cmd_q.rd && cmd_ok(cmd_q);
            wr_req.addr <= cmd_q.addr;
            wr_req.data <= shreg;
        end
    end

    // Read data leaves on falling edges of the second byte
    always_ff @(posedge clk) begin
        if (rst || csn_lvl) begin
            out_sh <= '0;
        end else if (sclk_fall) begin
            if (bit_cnt == CNT_BYTE)
                out_sh <= (cmd_q.rd && cmd_ok(cmd_q)) ? rd_data : '0;
            else if (bit_cnt > CNT_BYTE && bit_cnt < CNT_FRAME)
                out_sh <= {out_sh[DATA_W-2:0], 1'b0};
        end
    end

    assign sdo_bit = out_sh[DATA_W-1];

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        bit_cnt <= CNT_SAT);                                           // R5
    AST_STB_DESELECTED: assert property (@(posedge clk) disable iff (rst)
        wr_req.stb |-> csn_lvl);                                       // R3
    AST_SDO_QUIET: assert property (@(posedge clk) disable iff (rst)
        csn_lvl |=> (sdo_bit == 1'b0));                                // R9
    AST_CMD_HELD: assert property (@(posedge clk) disable iff (rst)
        (!csn_lvl && bit_cnt >= CNT_BYTE) |=> $stable(cmd_q));         // R2
endmodule

// File: rtl/gspi_regfile.sv
module gspi_regfile
    import gspi_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  wr_req_t                         wr_req,
    input  logic [ADDR_W-1:0]               rd_addr,
    output logic [DATA_W-1:0]               rd_data,
    output logic [NUM_REGS-1:0][DATA_W-1:0] regs
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        if (WR_MASK[i]) begin : g_rw
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= RST_VALS[i];
                else if (wr_req.stb && wr_req.addr == ADDR_W'(i))
                    q <= wr_req.data;
            end
            assign regs[i] = q;
        end else begin : g_ro
            assign regs[i] = RST_VALS[i];
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (rd_addr == ADDR_W'(i)) rd_data = regs[i];
    end

    AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        !wr_req.stb |=> $stable(regs));                                // R4
endmodule

// File: rtl/gain_spi_regs.sv
module gain_spi_regs
    import gspi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_clk,
    input  logic              spi_csn,
    input  logic              spi_sdi,
    output logic              spi_sdo,
    output logic              spi_sdo_oe,
    output logic [DATA_W-1:0] pwr_ctrl,
    output logic [DATA_W-1:0] atten_a,
    output logic [DATA_W-1:0] atten_b,
    output logic [DATA_W-1:0] chan_ctrl
);
    logic sclk_s, csn_s, sdi_s;
    logic sclk_prev, csn_prev;
    logic sclk_rise, sclk_fall, csn_rise;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic [NUM_REGS-1:0][DATA_W-1:0] regs;
    wr_req_t wr_req;
    logic sdo_bit;

    gspi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_clk (
        .clk(clk), .rst(rst), .din(spi_clk), .q(sclk_s));
    gspi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_csn (
        .clk(clk), .rst(rst), .din(spi_csn), .q(csn_s));
    gspi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdi (
        .clk(clk), .rst(rst), .din(spi_sdi), .q(sdi_s));

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_prev <= 1'b0;
            csn_prev  <= 1'b1;
        end else begin
            sclk_prev <= sclk_s;
            csn_prev  <= csn_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_prev;
    assign sclk_fall = ~sclk_s & sclk_prev;
    assign csn_rise  = csn_s & ~csn_prev;

    gspi_frame u_frame (
        .clk(clk), .rst(rst),
        .csn_lvl(csn_s), .csn_rise(csn_rise),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .sdi_lvl(sdi_s), .rd_data(rd_data),
        .rd_addr(rd_addr), .wr_req(wr_req), .sdo_bit(sdo_bit));

    gspi_regfile u_regs (
        .clk(clk), .rst(rst), .wr_req(wr_req),
        .rd_addr(rd_addr), .rd_data(rd_data), .regs(regs));

    assign spi_sdo_oe = ~spi_csn;
    assign spi_sdo    = spi_sdo_oe & sdo_bit;

    assign pwr_ctrl  = regs[ADR_PWR];
    assign atten_a   = regs[ADR_ATTA];
    assign atten_b   = regs[ADR_ATTB];
    assign chan_ctrl = regs[ADR_CHAN];

    AST_WR_TARGET: assert property (@(posedge clk) disable iff (rst)
        (wr_req.stb && wr_req.addr == ADR_ATTA) |=> (atten_a == $past(wr_req.data))); // R11
endmodule

// File: tb/gain_spi_regs_bench.sv
module gain_spi_regs_bench;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic spi_clk = 1'b0, spi_csn = 1'b1, spi_sdi = 1'b0;
    logic spi_sdo, spi_sdo_oe;
    logic [7:0] pwr_ctrl, atten_a, atten_b, chan_ctrl;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [8];

    always #2.5 clk = ~clk;

    gain_spi_regs u_gain_spi_regs (
        .clk(clk), .rst(rst), .spi_clk(spi_clk), .spi_csn(spi_csn),
        .spi_sdi(spi_sdi), .spi_sdo(spi_sdo), .spi_sdo_oe(spi_sdo_oe),
        .pwr_ctrl(pwr_ctrl), .atten_a(atten_a), .atten_b(atten_b),
        .chan_ctrl(chan_ctrl));

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic check_outputs(input string req);
        check({req, " pwr"},  pwr_ctrl,  model[2]);
        check({req, " attA"}, atten_a,   model[3]);
        check({req, " attB"}, atten_b,   model[4]);
        check({req, " chan"}, chan_ctrl, model[5]);
    endtask

    // One frame of nbits clocks; returns the byte seen on data-out in the data phase
    task automatic frame(input logic [7:0] cmd, input logic [7:0] data,
                         input int nbits, output logic [7:0] rd);
        logic [15:0] word;
        logic cmd_sdo_seen;
        word = {cmd, data};
        rd = 8'h00;
        cmd_sdo_seen = 1'b0;
        spi_csn = 1'b0;
        tick(HALF);
        check("R9 oe while selected", {7'd0, spi_sdo_oe}, 8'h01);
        for (int i = 0; i < nbits; i++) begin
            spi_sdi = (i < 16) ? word[15-i] : 1'b0;
            tick(HALF);
            if (i >= 8 && i < 16) rd[15-i] = spi_sdo;
            else if (spi_sdo) cmd_sdo_seen = 1'b1;
            spi_clk = 1'b1;
            tick(HALF);
            spi_clk = 1'b0;
        end
        tick(HALF);
        check("R9 sdo quiet outside data byte", {7'd0, cmd_sdo_seen}, 8'h00);
        check_outputs("R3 before deselect");
        spi_csn = 1'b1;
        tick(1);
        check("R9 oe released", {7'd0, spi_sdo_oe}, 8'h00);
        check("R9 sdo low when disabled", {7'd0, spi_sdo}, 8'h00);
        if (nbits == 16 && !cmd[7] && cmd[6:3] == 4'd0 && cmd[2:0] >= 3'd2 && cmd[2:0] <= 3'd5)
            model[cmd[2:0]] = data;
        tick(6);
    endtask

    function automatic logic [7:0] exp_read(input logic [7:0] cmd);
        if (!cmd[7] || cmd[6:3] != 4'd0) return 8'h00;
        return model[cmd[2:0]];
    endfunction

    task automatic wr(input logic [2:0] a, input logic [7:0] d, input string req);
        logic [7:0] rd;
        frame({5'b00000, a}, d, 16, rd);
        check({req, " write frame sdo"}, rd, 8'h00);
        check_outputs(req);
    endtask

    task automatic rd_chk(input logic [7:0] cmd, input logic [7:0] junk, input string req);
        logic [7:0] rd;
        logic [7:0] exp;
        exp = exp_read(cmd);
        frame(cmd, junk, 16, rd);
        check(req, rd, exp);
        check_outputs({req, " read leaves regs"});
    endtask

    initial begin
        model[0] = 8'h01; model[1] = 8'h21; model[2] = 8'h00; model[3] = 8'h50;
        model[4] = 8'h50; model[5] = 8'h03; model[6] = 8'h00; model[7] = 8'h00;
        tick(4);
        rst = 1'b0;
        tick(4);
        check_outputs("R1 reset");
        check("R1 oe idle", {7'd0, spi_sdo_oe}, 8'h00);

        // R8 R7: read every address at reset, data byte ignored
        for (int a = 0; a < 8; a++)
            rd_chk({5'b10000, 3'(a)}, 8'hFF, "R8 R7 reset read");

        // R6 R11: write every address with distinct data, read all back
        for (int a = 0; a < 8; a++)
            wr(3'(a), 8'(8'hA5 ^ (a * 37)), "R6 R11 write");
        for (int a = 0; a < 8; a++)
            rd_chk({5'b10000, 3'(a)}, 8'h5A, "R11 R8 readback");

        // R11 R2: sweep attenuation A and B values, MSB-first check
        for (int v = 0; v < 256; v += 17) begin
            wr(3'd3, 8'(v), "R2 R11 attA sweep");
            wr(3'd4, 8'(255 - v), "R2 R11 attB sweep");
            rd_chk(8'h83, 8'h00, "R7 attA sweep read");
            rd_chk(8'h84, 8'hC3, "R7 attB sweep read");
        end

        // R4: short frames of every length
        for (int n = 0; n < 16; n++) begin
            logic [7:0] rd;
            frame(8'h03, 8'(n + 8'h11), n, rd);
            check_outputs("R4 short frame");
        end

        // R5: over-long frames
        for (int n = 17; n < 21; n++) begin
            logic [7:0] rd;
            frame(8'h02, 8'hEE, n, rd);
            check_outputs("R5 long frame");
        end

        // R10: reserved bits set
        for (int r = 1; r < 16; r++) begin
            logic [7:0] rd;
            frame({1'b0, 4'(r), 3'd5}, 8'h77, 16, rd);
            check_outputs("R10 reserved write");
            frame({1'b1, 4'(r), 3'd3}, 8'h00, 16, rd);
            check("R10 reserved read", rd, 8'h00);
        end

        wr(3'd2, 8'h01, "R6 pwr");
        wr(3'd5, 8'h04, "R6 chan");
        rd_chk(8'h82, 8'h00, "R11 pwr read");
        rd_chk(8'h85, 8'h00, "R11 chan read");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog timeout");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule